// File: doc/BRIEF.md
# Midplane status and interrupt registers

This block is a small register file on a 32-bit host bus with an 8-bit offset. It reports which slots are populated and powered, and it latches hot-insertion, removal and memory-error events in a sticky word that the host clears by writing ones. It drives three level interrupts: network IO, slot management and insertion/removal. The host acknowledges each of them through a defined register access. Two of these acknowledges happen as a side effect of a read.

The block also has a plain 32-bit control register and two bit-banged serial EEPROM ports. The first port serves slots 0, 1, 3 and 4. The second serves slots 2, 5 and 6. A host write drives each slot's select, clock and data-in lines from fixed bit positions. A host read returns each slot's data-out line. Read data is registered and appears one clock after the request.

Top module: `midplane_regs`

## Requirements
- R1: A read at offset 0x10, 0x11, 0x12, 0x13, 0x18, 0x19 or 0x1A returns 0xFFFFFFFF and drops `irq_netio_o` on the clock that accepts it. Other offsets, such as 0x14, leave `irq_netio_o` alone.
- R2: Any access at offset 0x40, read or write, drops `irq_mgmt_o`. A read there returns the power-good word of R3 ANDed with 0x66666600.
- R3: A read at 0x50 returns the power-good word. Bits 1 and 2 are always set for slot 0. Slot s (1..6) sets both bits of its pair only while `slot_present_i[s-1]` is high. The pairs are: slot 1 at bits 9/10, slot 2 at 13/14, slot 3 at 25/26, slot 4 at 17/18, slot 5 at 29/30 and slot 6 at 21/22. All other bits are zero.
- R4: Offset 0x58 is a 32-bit read/write control register.
- R5: A high `slot_evt_i[s-1]` sets bit s of the event word at 0x70, and a high `mem_err_i` sets bit 7. Bits 0 and 8..31 read as zero. Any such event raises `irq_oir_o` on the next clock.
- R6: A write at 0x70 clears every event bit whose data bit is 1 and drops `irq_oir_o`. An event arriving in the same cycle still sets its bit and keeps `irq_oir_o` high.
- R7: Offsets 0x78, 0x7B and all unmapped offsets read as zero, and writes to them change no register, line or interrupt.
- R8: A write at 0x60 loads select from bit base+1, clock from bit base+3 and data-in from bit base+4 for each port-A slot. Index 0..3 of the port-A outputs is slot 0, 1, 3, 4, with bases 0, 8, 24, 16.
- R9: A write at 0x68 does the same for port B. Index 0..2 of the port-B outputs is slot 2, 5, 6, with bases 8, 24, 16. Neither port's write touches the other port.
- R10: A read at 0x60 or 0x68 returns each slot's data-out input at bit base+6 of its port, and zero at every other bit.
- R11: `rdata_o` is loaded on the clock edge that accepts a read and holds its value through writes and idle cycles.
- R12: Reset clears the control register, the event word, all three interrupts, `rdata_o` and every EEPROM output line.
- R13: `netio_evt_i` raises `irq_netio_o` and `mgmt_evt_i` raises `irq_mgmt_o` on the next clock. If a raise and an acknowledge arrive in the same cycle, the interrupt stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Register offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one clock after a read |
| slot_present_i | input | 6 | Slot 1..6 populated |
| slot_evt_i | input | 6 | Insertion/removal pulse, slot 1..6 |
| mem_err_i | input | 1 | Memory error pulse |
| netio_evt_i | input | 1 | Network IO interrupt source |
| mgmt_evt_i | input | 1 | Slot management interrupt source |
| irq_netio_o | output | 1 | Network IO interrupt level |
| irq_mgmt_o | output | 1 | Slot management interrupt level |
| irq_oir_o | output | 1 | Insertion/removal interrupt level |
| eep_a_sel_o | output | 4 | Port A select, slots 0,1,3,4 |
| eep_a_clk_o | output | 4 | Port A serial clock |
| eep_a_din_o | output | 4 | Port A data to EEPROM |
| eep_a_dout_i | input | 4 | Port A data from EEPROM |
| eep_b_sel_o | output | 3 | Port B select, slots 2,5,6 |
| eep_b_clk_o | output | 3 | Port B serial clock |
| eep_b_din_o | output | 3 | Port B data to EEPROM |
| eep_b_dout_i | input | 3 | Port B data from EEPROM |

## Verification
Every result is due exactly one clock after its stimulus. Read data, interrupt clears, interrupt raises, event bits and EEPROM lines all change on the rising edge that samples the request or pulse. The bench drives every request and pulse on a falling edge and releases it on the next falling edge. It then checks outputs at that second falling edge, so each check lands one edge after the stimulus. Same-cycle races between an event and its acknowledge are driven within a single falling-edge window, so that both reach the same rising edge.

// File: rtl/midplane_pkg.sv
package midplane_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned AW        = 8;
  localparam int unsigned NUM_SLOTS = 7;
  localparam int unsigned NUM_PLUG  = NUM_SLOTS - 1;
  localparam int unsigned NUM_EVT   = NUM_PLUG + 1;
  localparam int unsigned EEP_A_N   = 4;
  localparam int unsigned EEP_B_N   = 3;

  localparam logic [7:0] OFS_MGMT  = 8'h40;
  localparam logic [7:0] OFS_PWR   = 8'h50;
  localparam logic [7:0] OFS_CTRL  = 8'h58;
  localparam logic [7:0] OFS_EEP_A = 8'h60;
  localparam logic [7:0] OFS_EEP_B = 8'h68;
  localparam logic [7:0] OFS_EVT   = 8'h70;

  localparam logic [31:0] MGMT_MASK = 32'h6666_6600;

  localparam int unsigned EEP_SEL_OFS  = 1;
  localparam int unsigned EEP_CLK_OFS  = 3;
  localparam int unsigned EEP_DIN_OFS  = 4;
  localparam int unsigned EEP_DOUT_OFS = 6;

  // bases packed 5 bits each, index 0 in the low field
  localparam logic [EEP_A_N*5-1:0] EEP_A_BASES = {5'd16, 5'd24, 5'd8, 5'd0};
  localparam logic [EEP_B_N*5-1:0] EEP_B_BASES = {5'd16, 5'd24, 5'd8};

  typedef enum logic [2:0] {
    DEC_NONE, DEC_NETIO, DEC_MGMT, DEC_PWR,
    DEC_CTRL, DEC_EEP_A, DEC_EEP_B, DEC_EVT
  } dec_e;

  // low bit of each slot's power-good pair
  function automatic int unsigned pg_base(input int unsigned slot);
    case (slot)
      0: return 1;
      1: return 9;
      2: return 13;
      3: return 25;
      4: return 17;
      5: return 29;
      6: return 21;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/midplane_pwr_status.sv
module midplane_pwr_status
  import midplane_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic [NUM_PLUG-1:0] present_i,
  output logic [W-1:0]        pg_o
);
  always_comb begin
    pg_o = '0;
    pg_o[pg_base(0)]     = 1'b1;
    pg_o[pg_base(0) + 1] = 1'b1;
    for (int s = 1; s < NUM_SLOTS; s++) begin
      if (present_i[s-1]) begin
        pg_o[pg_base(s)]     = 1'b1;
        pg_o[pg_base(s) + 1] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/midplane_eep_port.sv
module midplane_eep_port
  import midplane_pkg::*;
#(
  parameter int unsigned       N     = 4,
  parameter int unsigned       W     = DW,
  parameter logic [N*5-1:0]    BASES = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [N-1:0] dout_i,
  output logic [N-1:0] sel_o,
  output logic [N-1:0] clk_o,
  output logic [N-1:0] din_o,
  output logic [W-1:0] rdata_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  for (genvar g = 0; g < N; g++) begin : g_slot
    localparam int unsigned BASE = int'(BASES[g*5 +: 5]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sel_o[g] <= 1'b0;
        clk_o[g] <= 1'b0;
        din_o[g] <= 1'b0;
      end else if (wr_i) begin
        sel_o[g] <= wdata_i[BASE + EEP_SEL_OFS];
        clk_o[g] <= wdata_i[BASE + EEP_CLK_OFS];
        din_o[g] <= wdata_i[BASE + EEP_DIN_OFS];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < int'(N); i++)
      rdata_o[int'(BASES[i*5 +: 5]) + EEP_DOUT_OFS] = dout_i[i];
  end
endmodule

// File: rtl/midplane_evt_reg.sv
module midplane_evt_reg
  import midplane_pkg::*;
#(
  parameter int unsigned N = NUM_EVT
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] evt_o,
  output logic         irq_o
);
  logic [N-1:0] clr_eff;
  assign clr_eff = clr_wr_i ? clr_mask_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_o <= '0;
      irq_o <= 1'b0;
    end else begin
      evt_o <= (evt_o & ~clr_eff) | set_i;  // new event beats clear
      if (|set_i)        irq_o <= 1'b1;
      else if (clr_wr_i) irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/midplane_regs.sv
module midplane_regs
  import midplane_pkg::*;
#(
  parameter int unsigned W  = DW,
  parameter int unsigned AWI = AW
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [AWI-1:0]      addr_i,
  input  logic [W-1:0]        wdata_i,
  output logic [W-1:0]        rdata_o,
  input  logic [NUM_PLUG-1:0] slot_present_i,
  input  logic [NUM_PLUG-1:0] slot_evt_i,
  input  logic                mem_err_i,
  input  logic                netio_evt_i,
  input  logic                mgmt_evt_i,
  output logic                irq_netio_o,
  output logic                irq_mgmt_o,
  output logic                irq_oir_o,
  output logic [EEP_A_N-1:0]  eep_a_sel_o,
  output logic [EEP_A_N-1:0]  eep_a_clk_o,
  output logic [EEP_A_N-1:0]  eep_a_din_o,
  input  logic [EEP_A_N-1:0]  eep_a_dout_i,
  output logic [EEP_B_N-1:0]  eep_b_sel_o,
  output logic [EEP_B_N-1:0]  eep_b_clk_o,
  output logic [EEP_B_N-1:0]  eep_b_din_o,
  input  logic [EEP_B_N-1:0]  eep_b_dout_i
);
  dec_e         dec;
  logic         rd, wr;
  logic [W-1:0] pg, ctrl_q, eep_a_rd, eep_b_rd, rd_mux;
  logic [NUM_EVT-1:0] evt;

  always_comb begin
    unique casez (addr_i[7:0])
      8'h10, 8'h11, 8'h12, 8'h13,
      8'h18, 8'h19, 8'h1a: dec = DEC_NETIO;
      OFS_MGMT:            dec = DEC_MGMT;
      OFS_PWR:             dec = DEC_PWR;
      OFS_CTRL:            dec = DEC_CTRL;
      OFS_EEP_A:           dec = DEC_EEP_A;
      OFS_EEP_B:           dec = DEC_EEP_B;
      OFS_EVT:             dec = DEC_EVT;
      default:             dec = DEC_NONE;
    endcase
  end

  assign rd = req_i && !we_i;
  assign wr = req_i &&  we_i;

  midplane_pwr_status #(.W(W)) u_pwr (
    .present_i (slot_present_i),
    .pg_o      (pg)
  );

  midplane_eep_port #(.N(EEP_A_N), .W(W), .BASES(EEP_A_BASES)) u_eep_a (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr && dec == DEC_EEP_A),
    .wdata_i (wdata_i),
    .dout_i  (eep_a_dout_i),
    .sel_o   (eep_a_sel_o),
    .clk_o   (eep_a_clk_o),
    .din_o   (eep_a_din_o),
    .rdata_o (eep_a_rd)
  );

  midplane_eep_port #(.N(EEP_B_N), .W(W), .BASES(EEP_B_BASES)) u_eep_b (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr && dec == DEC_EEP_B),
    .wdata_i (wdata_i),
    .dout_i  (eep_b_dout_i),
    .sel_o   (eep_b_sel_o),
    .clk_o   (eep_b_clk_o),
    .din_o   (eep_b_din_o),
    .rdata_o (eep_b_rd)
  );

  midplane_evt_reg #(.N(NUM_EVT)) u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      ({mem_err_i, slot_evt_i}),
    .clr_wr_i   (wr && dec == DEC_EVT),
    .clr_mask_i (wdata_i[NUM_EVT:1]),
    .evt_o      (evt),
    .irq_o      (irq_oir_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ctrl_q <= '0;
    else if (wr && dec == DEC_CTRL)  ctrl_q <= wdata_i;
  end

  // raise beats acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_netio_o <= 1'b0;
      irq_mgmt_o  <= 1'b0;
    end else begin
      if (netio_evt_i)                  irq_netio_o <= 1'b1;
      else if (rd && dec == DEC_NETIO)  irq_netio_o <= 1'b0;
      if (mgmt_evt_i)                   irq_mgmt_o <= 1'b1;
      else if (req_i && dec == DEC_MGMT) irq_mgmt_o <= 1'b0;
    end
  end

  always_comb begin
    case (dec)
      DEC_NETIO: rd_mux = '1;
      DEC_MGMT:  rd_mux = pg & W'(MGMT_MASK);
      DEC_PWR:   rd_mux = pg;
      DEC_CTRL:  rd_mux = ctrl_q;
      DEC_EEP_A: rd_mux = eep_a_rd;
      DEC_EEP_B: rd_mux = eep_b_rd;
      DEC_EVT:   rd_mux = W'({evt, 1'b0});
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_mux;
  end
endmodule

// File: rtl/midplane_regs_chk.sv
module midplane_regs_chk
  import midplane_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [7:0]          addr_i,
  input logic [31:0]         wdata_i,
  input logic [31:0]         rdata_o,
  input logic [NUM_PLUG-1:0] slot_evt_i,
  input logic                mem_err_i,
  input logic                netio_evt_i,
  input logic                mgmt_evt_i,
  input logic                irq_netio_o,
  input logic                irq_mgmt_o,
  input logic                irq_oir_o,
  input logic [EEP_A_N-1:0]  eep_a_sel_o
);
  logic netio_ofs;
  assign netio_ofs = (addr_i inside {8'h10, 8'h11, 8'h12, 8'h13, 8'h18, 8'h19, 8'h1a});

  assert_netio_ack_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && netio_ofs && !netio_evt_i |=> !irq_netio_o && rdata_o == 32'hffff_ffff);

  assert_mgmt_ack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && addr_i == OFS_MGMT && !mgmt_evt_i |=> !irq_mgmt_o);

  assert_evt_raise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|slot_evt_i || mem_err_i) |=> irq_oir_o);

  assert_oir_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && addr_i == OFS_EVT && !(|slot_evt_i) && !mem_err_i |=> !irq_oir_o);

  assert_quiet_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && (addr_i == 8'h78 || addr_i == 8'h7b) |=> rdata_o == '0);

  assert_eep_a_slot0_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && addr_i == OFS_EEP_A |=> eep_a_sel_o[0] == $past(wdata_i[1]));

  assert_rdata_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));

  assert_irq_raise_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    netio_evt_i |=> irq_netio_o);

  assert_mgmt_raise_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mgmt_evt_i |=> irq_mgmt_o);
endmodule

bind midplane_regs midplane_regs_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .slot_evt_i  (slot_evt_i),
  .mem_err_i   (mem_err_i),
  .netio_evt_i (netio_evt_i),
  .mgmt_evt_i  (mgmt_evt_i),
  .irq_netio_o (irq_netio_o),
  .irq_mgmt_o  (irq_mgmt_o),
  .irq_oir_o   (irq_oir_o),
  .eep_a_sel_o (eep_a_sel_o)
);

// File: tb/midplane_regs_bench.sv
`timescale 1ns/1ps
module midplane_regs_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 0, we = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0]  present = '0, sevt = '0;
  logic        merr = 0, nevt = 0, mevt = 0;
  logic        irq_n, irq_m, irq_o;
  logic [3:0]  a_sel, a_clk, a_din, a_dout = '0;
  logic [2:0]  b_sel, b_clk, b_din, b_dout = '0;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  midplane_regs u_midplane_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .slot_present_i(present),
    .slot_evt_i(sevt), .mem_err_i(merr), .netio_evt_i(nevt), .mgmt_evt_i(mevt),
    .irq_netio_o(irq_n), .irq_mgmt_o(irq_m), .irq_oir_o(irq_o),
    .eep_a_sel_o(a_sel), .eep_a_clk_o(a_clk), .eep_a_din_o(a_din), .eep_a_dout_i(a_dout),
    .eep_b_sel_o(b_sel), .eep_b_clk_o(b_clk), .eep_b_din_o(b_din), .eep_b_dout_i(b_dout)
  );

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [3:0]  rq;
  } vec_t;

  // present = slots 1,3,5 -> power word 0x66000606
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h50, 32'h0,        32'h6600_0606, 4'd3},  // R3
    '{1'b0, 8'h40, 32'h0,        32'h6600_0600, 4'd2},  // R2
    '{1'b1, 8'h58, 32'hdead_beef, 32'h0,        4'd4},  // R4 write
    '{1'b0, 8'h58, 32'h0,        32'hdead_beef, 4'd4},  // R4
    '{1'b0, 8'h10, 32'h0,        32'hffff_ffff, 4'd1},  // R1
    '{1'b0, 8'h1a, 32'h0,        32'hffff_ffff, 4'd1},  // R1
    '{1'b0, 8'h14, 32'h0,        32'h0,         4'd7},  // R7 gap
    '{1'b1, 8'h78, 32'h1234_5678, 32'h0,        4'd7},  // R7 write
    '{1'b0, 8'h78, 32'h0,        32'h0,         4'd7},  // R7
    '{1'b1, 8'h7b, 32'hffff_ffff, 32'h0,        4'd7},  // R7 write
    '{1'b0, 8'h58, 32'h0,        32'hdead_beef, 4'd7},  // R7 ctrl untouched
    '{1'b0, 8'h70, 32'h0,        32'h0,         4'd5}   // R5 no events yet
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 irqs", {29'b0, irq_n, irq_m, irq_o}, 32'h0);
    check("R12 eep lines", {11'b0, a_sel, a_clk, a_din, b_sel, b_clk, b_din}, 32'h0);
    check("R12 rdata", rdata, 32'h0);
    rst_n = 1;
    acc(0, 8'h58, 0); check("R12 ctrl", rdata, 32'h0);
    acc(0, 8'h70, 0); check("R12 evt", rdata, 32'h0);

    present = 6'b010101;
    for (int i = 0; i < NV; i++) begin
      acc(VEC[i].we, VEC[i].addr, VEC[i].wdata);
      if (!VEC[i].we) check($sformatf("R%0d vec %0d", VEC[i].rq, i), rdata, VEC[i].exp);
    end

    // R3 other population patterns, R2 masking
    present = 6'b111111;
    acc(0, 8'h50, 0); check("R3 all", rdata, 32'h6666_6606);
    present = 6'b000000;
    acc(0, 8'h50, 0); check("R3 none", rdata, 32'h0000_0006);
    acc(0, 8'h40, 0); check("R2 none", rdata, 32'h0);
    present = 6'b101010;
    acc(0, 8'h40, 0); check("R2 2,4,6", rdata, 32'h0066_6000);

    // R13 / R1 netio
    @(negedge clk); nevt = 1; @(negedge clk); nevt = 0;
    check("R13 netio raise", {31'b0, irq_n}, 1);
    acc(0, 8'h14, 0); check("R1 no ack at 0x14", {31'b0, irq_n}, 1);
    acc(1, 8'h11, 0); check("R1 write no ack", {31'b0, irq_n}, 1);
    acc(0, 8'h11, 0); check("R1 ack", {31'b0, irq_n}, 0);
    @(negedge clk); nevt = 1; req = 1; we = 0; addr = 8'h12;
    @(negedge clk); nevt = 0; req = 0;
    check("R13 raise beats ack", {31'b0, irq_n}, 1);
    acc(0, 8'h18, 0); check("R1 ack 0x18", {31'b0, irq_n}, 0);

    // R2 mgmt
    @(negedge clk); mevt = 1; @(negedge clk); mevt = 0;
    check("R13 mgmt raise", {31'b0, irq_m}, 1);
    acc(1, 8'h40, 32'hffff_ffff); check("R2 write ack", {31'b0, irq_m}, 0);
    @(negedge clk); mevt = 1; @(negedge clk); mevt = 0;
    acc(0, 8'h40, 0); check("R2 read ack", {31'b0, irq_m}, 0);

    // R5 / R6 events
    @(negedge clk); sevt = 6'b000100; merr = 1;
    @(negedge clk); sevt = '0; merr = 0;
    check("R5 irq", {31'b0, irq_o}, 1);
    acc(0, 8'h70, 0); check("R5 evt word", rdata, 32'h88);
    acc(1, 8'h70, 32'h08); check("R6 irq clear", {31'b0, irq_o}, 0);
    acc(0, 8'h70, 0); check("R6 partial clear", rdata, 32'h80);
    @(negedge clk); req = 1; we = 1; addr = 8'h70; wdata = 32'h82; sevt = 6'b000001;
    @(negedge clk); req = 0; we = 0; sevt = '0;
    check("R6 event wins irq", {31'b0, irq_o}, 1);
    acc(0, 8'h70, 0); check("R6 event wins bit", rdata, 32'h02);

    // R8 / R9 EEPROM drive
    acc(1, 8'h60, 32'h1002_0802);
    check("R8 port A", {20'b0, a_sel, a_clk, a_din}, {20'b0, 4'b1001, 4'b0010, 4'b0100});
    check("R9 port B untouched", {23'b0, b_sel, b_clk, b_din}, 32'h0);
    acc(1, 8'h68, 32'h1002_0800);
    check("R9 port B", {23'b0, b_sel, b_clk, b_din}, {23'b0, 3'b100, 3'b001, 3'b010});
    check("R9 port A kept", {20'b0, a_sel, a_clk, a_din}, {20'b0, 4'b1001, 4'b0010, 4'b0100});
    acc(1, 8'h7b, 32'h0);
    check("R7 eep kept", {20'b0, a_sel, a_clk, a_din}, {20'b0, 4'b1001, 4'b0010, 4'b0100});

    // R10 data-out readback
    a_dout = 4'b1010; b_dout = 3'b011;
    acc(0, 8'h60, 0); check("R10 port A", rdata, 32'h0040_4000);
    acc(0, 8'h68, 0); check("R10 port B", rdata, 32'h4000_4000);

    // R11 hold through writes and idle
    acc(1, 8'h58, 32'h1);
    repeat (2) @(negedge clk);
    check("R11 hold", rdata, 32'h4000_4000);

    finish_run();
  end
endmodule